// File: doc/BRIEF.md
# Reconfigurable Shift-and-Add Coefficient Multiplier

This block multiplies a signed input sample by a coefficient that can be changed at run time, and it uses no general multiplier. It builds a small set of shared multiples of the sample, {0, x, 2x, 3x}, from one shift and one addition. The coefficient magnitude is read as a string of 2-bit digits. Each digit drives a multiplexer that picks the matching multiple. That multiple is then moved left by twice the digit's position.

The weighted terms are combined by a chain of 3:2 carry-save stages. A single ripple-carry add then joins the final sum and carry vectors. The coefficient has a separate sign bit, so it is held in sign-magnitude form. When that bit is set and the magnitude is non-zero, the result is negated. The product has full precision and leaves the block through a register, one cycle after the sample is accepted.

A typical use is as one tap of a pulse-shaping filter whose coefficient set is reloaded when the air standard changes. The delay line and the accumulation across taps sit outside this block.

Top module: `bcse_coef_mult`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, out_valid is 0 and product is 0. The held coefficient resets to magnitude 0, sign positive.
- R2: When in_valid is 1 at a clock edge and the held sign is 0, product after that edge equals the 16-bit two's-complement in_sample times the unsigned 16-bit held magnitude. This is exact, as a 32-bit two's-complement value.
- R3: When the held sign is 1, product is the two's-complement negation of the R2 value.
- R4: A held magnitude of 0 gives a product of all zeros, whatever the sign bit.
- R5: out_valid at each edge takes the value in_valid had at the previous edge, so the latency is one cycle.
- R6: coef_load = 1 at an edge captures coef_mag and coef_neg. A sample accepted at that same edge still uses the previous coefficient. The new coefficient applies from the next accepted sample.
- R7: While in_valid is 0, product holds its last value, whatever in_sample does.
- R8: The extreme operands are exact, including in_sample = -32768 with magnitude 65535 and either sign.
- R9: Magnitude bits [2k+1:2k] form digit k, for k = 0..7. Digit values 0, 1, 2 and 3 contribute 0, x, 2x and 3x, each weighted by 4^k. Every single-digit coefficient gives that value times x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Two's-complement input sample |
| coef_load | input | 1 | Coefficient capture strobe |
| coef_mag | input | 16 | Coefficient magnitude |
| coef_neg | input | 1 | Coefficient sign, 1 = negative |
| out_valid | output | 1 | Product strobe, one cycle after in_valid |
| product | output | 32 | Registered two's-complement product |

## Verification
An internal fault shows at the ports on the cycle right after the affected sample, because the only register between input and output is the product register. A wrong multiplexer choice or a broken carry in the reduction chain changes the product only for coefficients that have a given digit value at a given position. The bench therefore sweeps every single-digit coefficient against edge-case samples, in both signs. A coefficient register that loads at the wrong moment shows only when a load and a sample share an edge, so that case is driven on purpose.

// File: rtl/bcse_pkg.sv
package bcse_pkg;
  localparam int unsigned DIGIT_W = 2;
  localparam int unsigned N_MULT  = 4;

  typedef enum logic [DIGIT_W-1:0] {
    PICK_ZERO  = 2'b00,
    PICK_ONE   = 2'b01,
    PICK_TWO   = 2'b10,
    PICK_THREE = 2'b11
  } digit_pick_e;
endpackage

// File: rtl/bcse_multiples.sv
module bcse_multiples #(
  parameter int DATA_W = 16,
  parameter int TERM_W = DATA_W + 2
) (
  input  logic [DATA_W-1:0]                          sample,
  output logic [bcse_pkg::N_MULT-1:0][TERM_W-1:0]    mults
);
  logic [TERM_W-1:0] x_ext;
  logic [TERM_W-1:0] x_dbl;

  assign x_ext = {{(TERM_W-DATA_W){sample[DATA_W-1]}}, sample};
  assign x_dbl = x_ext << 1;

  assign mults[0] = '0;
  assign mults[1] = x_ext;
  assign mults[2] = x_dbl;
  assign mults[3] = x_ext + x_dbl;
endmodule

// File: rtl/bcse_digit_mux.sv
module bcse_digit_mux #(
  parameter int TERM_W = 18,
  parameter int DIGITS = 8,
  parameter int PROD_W = 32
) (
  input  logic [2*DIGITS-1:0]                        mag,
  input  logic [bcse_pkg::N_MULT-1:0][TERM_W-1:0]    mults,
  output logic [DIGITS-1:0][PROD_W-1:0]              terms
);
  import bcse_pkg::*;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    digit_pick_e       pick;
    logic [TERM_W-1:0] chosen;
    logic [PROD_W-1:0] widened;

    assign pick = digit_pick_e'(mag[DIGIT_W*g +: DIGIT_W]);

    always_comb begin
      unique case (pick)
        PICK_ZERO:  chosen = mults[0];
        PICK_ONE:   chosen = mults[1];
        PICK_TWO:   chosen = mults[2];
        PICK_THREE: chosen = mults[3];
        default:    chosen = '0;
      endcase
    end

    assign widened  = {{(PROD_W-TERM_W){chosen[TERM_W-1]}}, chosen};
    assign terms[g] = widened << (DIGIT_W*g);
  end
endmodule

// File: rtl/bcse_csa_chain.sv
module bcse_csa_chain #(
  parameter int N_OPS = 8,
  parameter int W     = 32
) (
  input  logic [N_OPS-1:0][W-1:0] ops,
  output logic [W-1:0]            total
);
  localparam int STAGES = N_OPS - 1;

  logic [STAGES-1:0][W-1:0] sum_v;
  logic [STAGES-1:0][W-1:0] cry_v;

  assign sum_v[0] = ops[0];
  assign cry_v[0] = ops[1];

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    logic [W-1:0] a, b, c;
    assign a = sum_v[i-1];
    assign b = cry_v[i-1];
    assign c = ops[i+1];
    assign sum_v[i] = a ^ b ^ c;
    assign cry_v[i] = ((a & b) | (a & c) | (b & c)) << 1;
  end

  always_comb begin
    logic rc;
    rc = 1'b0;
    for (int k = 0; k < W; k++) begin
      total[k] = sum_v[STAGES-1][k] ^ cry_v[STAGES-1][k] ^ rc;
      rc = (sum_v[STAGES-1][k] & cry_v[STAGES-1][k]) |
           (rc & (sum_v[STAGES-1][k] ^ cry_v[STAGES-1][k]));
    end
  end
endmodule

// File: rtl/bcse_coef_mult.sv
module bcse_coef_mult #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_sample,
  input  logic                     coef_load,
  input  logic [COEF_W-1:0]        coef_mag,
  input  logic                     coef_neg,
  output logic                     out_valid,
  output logic [DATA_W+COEF_W-1:0] product
);
  localparam int DIGITS = COEF_W / 2;
  localparam int TERM_W = DATA_W + 2;
  localparam int PROD_W = DATA_W + COEF_W;

  logic [COEF_W-1:0] coef_mag_q;
  logic              coef_neg_q;
  logic [bcse_pkg::N_MULT-1:0][TERM_W-1:0] mults;
  logic [DIGITS-1:0][PROD_W-1:0]           terms;
  logic [PROD_W-1:0] mag_prod;
  logic              mag_is_zero;
  logic              flip_sign;
  logic [PROD_W-1:0] prod_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_mag_q <= '0;
      coef_neg_q <= 1'b0;
    end else if (coef_load) begin
      coef_mag_q <= coef_mag;
      coef_neg_q <= coef_neg;
    end
  end

  bcse_multiples #(.DATA_W(DATA_W), .TERM_W(TERM_W)) u_mult (
    .sample (in_sample),
    .mults  (mults)
  );

  bcse_digit_mux #(.TERM_W(TERM_W), .DIGITS(DIGITS), .PROD_W(PROD_W)) u_mux (
    .mag   (coef_mag_q),
    .mults (mults),
    .terms (terms)
  );

  bcse_csa_chain #(.N_OPS(DIGITS), .W(PROD_W)) u_csa (
    .ops   (terms),
    .total (mag_prod)
  );

  assign mag_is_zero = ~|coef_mag_q;
  assign flip_sign   = coef_neg_q & ~mag_is_zero;
  assign prod_next   = flip_sign ? (~mag_prod + 1'b1) : mag_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= prod_next;
    end
  end
endmodule

// File: rtl/bcse_coef_mult_chk.sv
module bcse_coef_mult_chk #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [DATA_W-1:0]        in_sample,
  input logic                     coef_load,
  input logic [COEF_W-1:0]        coef_mag,
  input logic                     coef_neg,
  input logic                     out_valid,
  input logic [DATA_W+COEF_W-1:0] product,
  input logic [COEF_W-1:0]        coef_mag_q,
  input logic                     coef_neg_q
);
  localparam int PW = DATA_W + COEF_W;

  function automatic logic [PW-1:0] ref_mul(input logic [DATA_W-1:0] x,
                                            input logic [COEF_W-1:0] m,
                                            input logic n);
    logic signed [PW:0] a, b, p;
    a = $signed({{(COEF_W+1){x[DATA_W-1]}}, x});
    b = $signed({{(DATA_W+1){1'b0}}, m});
    p = a * b;
    if (n) p = -p;
    return p[PW-1:0];
  endfunction

  assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> product == $past(product));

  assert_zero_mag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(coef_mag_q) == '0) |-> product == '0);

  assert_positive_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && !$past(coef_neg_q)) |->
      product == ref_mul($past(in_sample), $past(coef_mag_q), 1'b0));

  assert_negative_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(coef_neg_q)) |->
      product == ref_mul($past(in_sample), $past(coef_mag_q), 1'b1));

  assert_coef_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coef_load |=> (coef_mag_q == $past(coef_mag) && coef_neg_q == $past(coef_neg)));
endmodule

bind bcse_coef_mult bcse_coef_mult_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .coef_load  (coef_load),
  .coef_mag   (coef_mag),
  .coef_neg   (coef_neg),
  .out_valid  (out_valid),
  .product    (product),
  .coef_mag_q (coef_mag_q),
  .coef_neg_q (coef_neg_q)
);

// File: tb/sim_bcse_coef_mult.sv
`timescale 1ns/1ps
module sim_bcse_coef_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        coef_load = 1'b0;
  logic [15:0] coef_mag = '0;
  logic        coef_neg = 1'b0;
  logic        out_valid;
  logic [31:0] product;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcse_coef_mult u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_load(coef_load), .coef_mag(coef_mag), .coef_neg(coef_neg),
    .out_valid(out_valid), .product(product)
  );

  function automatic logic [31:0] expect_of(logic [15:0] x, logic [15:0] m, logic n);
    longint e;
    e = longint'($signed(x)) * longint'(m);
    if (n) e = -e;
    return e[31:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [15:0] m, logic n);
    @(negedge clk);
    coef_load = 1'b1; coef_mag = m; coef_neg = n;
    @(negedge clk);
    coef_load = 1'b0;
  endtask

  // drive one sample, check product and valid, then idle cycle checks hold
  task automatic shot(string req, logic [15:0] x, logic [31:0] exp);
    logic [31:0] held;
    in_valid = 1'b1; in_sample = x;
    @(negedge clk);
    in_valid = 1'b0; in_sample = ~x;
    check(req, product, exp);
    check("R5 valid high", {31'b0, out_valid}, 32'd1);
    held = product;
    @(negedge clk);
    check("R5 valid low", {31'b0, out_valid}, 32'd0);
    check("R7 hold", product, held);
  endtask

  initial begin
    automatic logic [15:0] xs[8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                     16'h8000, 16'h3039, 16'hFCF7, 16'h5555};
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'b0, out_valid}, 32'd0);
    check("R1 product in reset", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {31'b0, out_valid}, 32'd0);
    check("R1 product after reset", product, 32'd0);
    @(negedge clk);
    // R1: held coefficient starts at zero
    shot("R1 reset coef zero", 16'h1234, 32'd0);

    // R9 / R2 / R3: every single-digit coefficient, both signs
    for (int k = 0; k < 8; k++)
      for (int d = 1; d < 4; d++)
        for (int s = 0; s < 2; s++) begin
          automatic logic [15:0] m = 16'(d) << (2*k);
          load(m, s[0]);
          for (int i = 0; i < 8; i++)
            shot(s ? "R9 R3 digit" : "R9 R2 digit", xs[i], expect_of(xs[i], m, s[0]));
        end

    // R4: zero magnitude with sign set
    load(16'h0000, 1'b1);
    for (int i = 0; i < 8; i++) shot("R4 zero mag", xs[i], 32'd0);

    // R8: extremes
    load(16'hFFFF, 1'b0);
    shot("R8 max pos", 16'h8000, expect_of(16'h8000, 16'hFFFF, 1'b0));
    shot("R8 max pos2", 16'h7FFF, expect_of(16'h7FFF, 16'hFFFF, 1'b0));
    load(16'hFFFF, 1'b1);
    shot("R8 max neg", 16'h8000, expect_of(16'h8000, 16'hFFFF, 1'b1));
    shot("R8 max neg2", 16'h7FFF, expect_of(16'h7FFF, 16'hFFFF, 1'b1));

    // R6: load and sample on the same edge
    load(16'h0007, 1'b0);
    @(negedge clk);
    coef_load = 1'b1; coef_mag = 16'h0100; coef_neg = 1'b1;
    in_valid = 1'b1; in_sample = 16'h0011;
    @(negedge clk);
    coef_load = 1'b0; in_valid = 1'b0;
    check("R6 old coef used", product, expect_of(16'h0011, 16'h0007, 1'b0));
    shot("R6 new coef applies", 16'h0011, expect_of(16'h0011, 16'h0100, 1'b1));

    // R2 / R3: random coefficients and samples
    for (int j = 0; j < 400; j++) begin
      automatic logic [15:0] m = 16'($urandom);
      automatic logic        n = 1'($urandom);
      load(m, n);
      for (int i = 0; i < 4; i++) begin
        automatic logic [15:0] x = 16'($urandom);
        shot(n ? "R3 random" : "R2 random", x, expect_of(x, m, n));
      end
    end

    // R5: back-to-back samples
    load(16'h00A5, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_sample = 16'h0003;
    @(negedge clk);
    check("R5 stream 1", product, expect_of(16'h0003, 16'h00A5, 1'b0));
    in_sample = 16'hFFF0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 stream 2", product, expect_of(16'hFFF0, 16'h00A5, 1'b0));
    check("R5 stream valid", {31'b0, out_valid}, 32'd1);
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule